// File: doc/BRIEF.md
# Line-frequency clock lock comparator

This block keeps a master clock locked to the mains frequency, so that integration periods which span whole line cycles reject line-related noise. A squared-up mains signal, synchronous to the master clock, is divided by two. Every second rising edge of that signal opens a measurement, and the next rising edge closes the line window, which is one line period long. When the measurement opens, an estimate chain also starts. The chain halves the master clock, divides it by a programmable ratio to give twice the estimated line frequency, and then divides by two again. The estimate window therefore closes a fixed number of master cycles after it opened.

The interval between the two window closings is sent out as a correction pulse, so its width in cycles equals the frequency error. A direction level records which window closed first. A low line period, measured in master cycles, means the clock runs slow, so the trim count goes up. A long line period means the clock runs fast, so the trim count goes down. For every clock cycle the correction pulse is high, the saturating trim register moves by one step in the direction given by that level. The trim value is the block's output and steers the external oscillator. The division ratio is an input, so the same block serves 50 Hz and 60 Hz mains. If line edges stop arriving, the block declares itself unlocked and holds the trim value.

Top module: `line_lock_cmp`

## Requirements
- R1: After reset, `trim` equals 2^(TRIM_W-1), and `corr_pulse`, `dir_up` and `unlocked` are all 0.
- R2: Counting from reset, the 1st, 3rd, 5th and later odd rising edges of `line_sq` each open a measurement. The rising edge after each one closes the line window, so the line window lasts L cycles, where L is the line period in master clock cycles.
- R3: The estimate window opens at the same clock edge as the line window. It closes exactly 4·`est_div` cycles later: a divide by 2, then a divide by `est_div`, then a divide by 2 of two terminal ticks. `est_div` must be nonzero.
- R4: Each measurement drives `corr_pulse` high for exactly |L − 4·`est_div`| cycles, and does not pulse it at all when the two windows are equal.
- R5: `dir_up` becomes 1 when the line window closes first, which means the clock is slow. It becomes 0 when the estimate window closes first. It keeps its value when both windows close together and between measurements.
- R6: `trim` moves by one count at the clock edge after each cycle in which `corr_pulse` is high: up when `dir_up` is 1, down when it is 0. Two measurements therefore move it by ±2·|L − 4·`est_div`| in total.
- R7: `trim` saturates at 0 and at 2^TRIM_W − 1 and never wraps.
- R8: `unlocked` rises 8·`est_div` + 1 cycles after the clock edge that sampled the last rising edge of `line_sq`, provided no further edge arrives. It clears at the clock edge that samples the next rising edge.
- R9: Going unlocked closes any open window, which ends the correction pulse. `trim` then holds. If a measurement loses its closing line edge after the estimate window has closed, `trim` falls by exactly 4·`est_div` + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_sq | input | 1 | Squared mains signal, synchronous to `clk` |
| est_div | input | DIV_W | Estimate divider ratio (nonzero) |
| trim | output | TRIM_W | Saturating oscillator trim count |
| corr_pulse | output | 1 | Correction pulse, width equals the frequency error in cycles |
| dir_up | output | 1 | 1 = clock slow (trim rises), 0 = clock fast (trim falls) |
| unlocked | output | 1 | Line edges missing; trim frozen |

## Verification
Each result is timed from the clock edge that samples a rising edge of `line_sq`. `corr_pulse` and `dir_up` change at the edge that closes the first window. `trim` moves one edge after every high cycle of `corr_pulse`. `unlocked` appears at edge 8·`est_div`+1 after the last sampled line edge, and the internal reset release adds two cycles before any of this starts. The bench drives inputs and samples outputs on falling edges. It checks `unlocked` on the falling edges just before and just after its due edge, and reads `trim`, the summed pulse width and `dir_up` only once both windows of the second measurement have closed, so no check depends on how the pulse lines up within a cycle.

// File: rtl/llk_pkg.sv
package llk_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } llk_dir_e;
endpackage

// File: rtl/llk_line_front.sv
module llk_line_front #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_sq,
  input  logic [CNT_W-1:0] sil_lim,
  output logic             rise,
  output logic             meas_start,
  output logic             line_stop,
  output logic             abort,
  output logic             unlocked
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic             line_q;
  logic             half_q, half_d;
  logic             unl_q, unl_d;
  logic [CNT_W-1:0] sil_q, sil_d;

  assign rise       = line_sq & ~line_q;
  assign meas_start = rise & ~half_q;
  assign line_stop  = rise & half_q;
  assign abort      = ~rise & (sil_q == sil_lim);
  assign unlocked   = unl_q;

  always_comb begin
    half_d = half_q ^ rise;
    sil_d  = sil_q;
    unl_d  = unl_q;
    if (rise) begin
      sil_d = '0;
      unl_d = 1'b0;
    end else if (sil_q == sil_lim) begin
      unl_d = 1'b1;
    end else begin
      sil_d = sil_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      half_q <= 1'b0;
      sil_q  <= '0;
      unl_q  <= 1'b0;
    end else begin
      line_q <= line_sq;
      half_q <= half_d;
      sil_q  <= sil_d;
      unl_q  <= unl_d;
    end
  end

  assert_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !unlocked);
  assert_lock_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> unlocked);
endmodule

// File: rtl/llk_est_win.sv
module llk_est_win #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DIV_W-1:0] div,
  output logic             est_open,
  output logic             est_close
);
  localparam logic [DIV_W-1:0] ONE     = 1;
  localparam logic [DIV_W+1:0] LEN_ONE = 1;

  logic             open_q, open_d;
  logic             pre_q, pre_d;
  logic             half_q, half_d;
  logic [DIV_W-1:0] rc_q, rc_d;
  logic             rc_wrap;

  assign rc_wrap   = pre_q & (rc_q == div - ONE);
  assign est_close = open_q & rc_wrap & half_q;
  assign est_open  = open_q;

  always_comb begin
    open_d = open_q;
    pre_d  = pre_q;
    rc_d   = rc_q;
    half_d = half_q;
    if (abort) begin
      open_d = 1'b0;
    end else if (start) begin
      open_d = 1'b1;
      pre_d  = 1'b0;
      rc_d   = '0;
      half_d = 1'b0;
    end else if (open_q) begin
      pre_d = ~pre_q;
      if (pre_q) rc_d = rc_wrap ? '0 : rc_q + ONE;
      if (rc_wrap) half_d = ~half_q;
      if (est_close) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pre_q  <= 1'b0;
      half_q <= 1'b0;
      rc_q   <= '0;
    end else begin
      open_q <= open_d;
      pre_q  <= pre_d;
      half_q <= half_d;
      rc_q   <= rc_d;
    end
  end

  // Independent length counter used only by the window-length check.
  logic [DIV_W+1:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (start)  len_q <= '0;
    else if (open_q) len_q <= len_q + LEN_ONE;
  end

  assert_est_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    est_close |-> (len_q + LEN_ONE) == {div, 2'b00});
endmodule

// File: rtl/llk_phase.sv
module llk_phase
  import llk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic line_stop,
  input  logic abort,
  input  logic est_open,
  input  logic est_close,
  output logic corr_pulse,
  output logic dir_up
);
  logic     lo_q, lo_d;
  llk_dir_e dir_q, dir_d;

  assign corr_pulse = lo_q ^ est_open;
  assign dir_up     = (dir_q == DIR_UP);

  always_comb begin
    lo_d = lo_q;
    if (abort)          lo_d = 1'b0;
    else if (start)     lo_d = 1'b1;
    else if (line_stop) lo_d = 1'b0;
    dir_d = dir_q;
    if (lo_q && line_stop && est_open && !est_close) dir_d = DIR_UP;
    else if (lo_q && est_close && !line_stop)        dir_d = DIR_DOWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= 1'b0;
      dir_q <= DIR_DOWN;
    end else begin
      lo_q  <= lo_d;
      dir_q <= dir_d;
    end
  end

  assert_dir_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_q && !est_open) |=> $stable(dir_up));
  assert_pulse_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !corr_pulse);
endmodule

// File: rtl/llk_trim.sv
module llk_trim #(
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              up,
  output logic [TRIM_W-1:0] trim
);
  localparam logic [TRIM_W-1:0] TMAX = '1;
  localparam logic [TRIM_W-1:0] TMID = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [TRIM_W-1:0] ONE  = 1;

  logic [TRIM_W-1:0] trim_q, trim_d;

  assign trim = trim_q;

  always_comb begin
    trim_d = trim_q;
    if (step_en) begin
      if (up) trim_d = (trim_q == TMAX) ? trim_q : trim_q + ONE;
      else    trim_d = (trim_q == '0)   ? trim_q : trim_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trim_q <= TMID;
    else        trim_q <= trim_d;
  end

  assert_no_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && up && trim == TMAX) |=> trim == TMAX);
  assert_no_wrap_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !up && trim == '0) |=> trim == '0);
endmodule

// File: rtl/line_lock_cmp.sv
module line_lock_cmp #(
  parameter int DIV_W  = 8,
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_sq,
  input  logic [DIV_W-1:0]  est_div,
  output logic [TRIM_W-1:0] trim,
  output logic              corr_pulse,
  output logic              dir_up,
  output logic              unlocked
);
  localparam int CNT_W = DIV_W + 3;

  logic [1:0]       rst_ff;
  logic             rst_sync_n;
  logic [CNT_W-1:0] sil_lim;
  logic             rise, meas_start, line_stop, abort;
  logic             est_open, est_close;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  // Silence limit: two expected line periods of 4*est_div cycles.
  assign sil_lim = {est_div, 3'b000};

  llk_line_front #(.CNT_W(CNT_W)) u_front (
    .clk(clk), .rst_n(rst_sync_n), .line_sq(line_sq), .sil_lim(sil_lim),
    .rise(rise), .meas_start(meas_start), .line_stop(line_stop),
    .abort(abort), .unlocked(unlocked)
  );

  llk_est_win #(.DIV_W(DIV_W)) u_est (
    .clk(clk), .rst_n(rst_sync_n), .start(meas_start), .abort(abort),
    .div(est_div), .est_open(est_open), .est_close(est_close)
  );

  llk_phase u_phase (
    .clk(clk), .rst_n(rst_sync_n), .start(meas_start), .line_stop(line_stop),
    .abort(abort), .est_open(est_open), .est_close(est_close),
    .corr_pulse(corr_pulse), .dir_up(dir_up)
  );

  llk_trim #(.TRIM_W(TRIM_W)) u_trim (
    .clk(clk), .rst_n(rst_sync_n), .step_en(corr_pulse & ~unlocked),
    .up(dir_up), .trim(trim)
  );

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unlocked |=> $stable(trim));
endmodule

// File: tb/line_lock_cmp_tb.sv
module line_lock_cmp_tb;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int TW = 8;
  localparam int MID = 1 << (TW - 1);
  localparam int TOP = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line_sq;
  logic [DW-1:0] est_div;
  logic [TW-1:0] trim;
  logic          corr_pulse, dir_up, unlocked;

  int vecs = 0;
  int bad = 0;
  int corr_cnt = 0;
  bit mon_en = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  line_lock_cmp #(.DIV_W(DW), .TRIM_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_sq(line_sq), .est_div(est_div),
    .trim(trim), .corr_pulse(corr_pulse), .dir_up(dir_up), .unlocked(unlocked)
  );

  always @(negedge clk) if (mon_en && corr_pulse) corr_cnt++;

  task automatic chk(input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input int n);
    mon_en  = 1'b0;
    line_sq = 1'b0;
    est_div = n[DW-1:0];
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    corr_cnt = 0;
    mon_en   = 1'b1;
  endtask

  // One line period starting with a rise seen at the next clock edge.
  task automatic line_period(input int l);
    line_sq = 1'b1;
    repeat (l / 2) @(negedge clk);
    line_sq = 1'b0;
    repeat (l - l / 2) @(negedge clk);
  endtask

  function automatic int clampv(input int v);
    if (v < 0) return 0;
    if (v > TOP) return TOP;
    return v;
  endfunction

  // Two full measurements at line period l, then silence.
  task automatic run_cfg(input int n, input int l);
    int w, lim, exp_trim, exp_dir;
    do_reset(n);
    lim = 8 * n;
    w = (l > 4 * n) ? l - 4 * n : 4 * n - l;
    exp_dir  = (l < 4 * n) ? 1 : 0;
    exp_trim = clampv(MID + ((l < 4 * n) ? 2 * w : -2 * w));
    for (int k = 0; k < 4; k++) line_period(l);
    repeat (lim + 1 - l) @(negedge clk);
    chk($sformatf("R8 still locked n=%0d l=%0d", n, l), unlocked, 0);
    chk($sformatf("R4 R2 R3 pulse width n=%0d l=%0d", n, l), corr_cnt, 2 * w);
    chk($sformatf("R5 direction n=%0d l=%0d", n, l), dir_up, exp_dir);
    chk($sformatf("R6 R7 trim n=%0d l=%0d", n, l), trim, exp_trim);
    @(negedge clk);
    chk($sformatf("R8 unlock due n=%0d l=%0d", n, l), unlocked, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset(3);
    chk("R1 trim at reset", trim, MID);
    chk("R1 corr_pulse at reset", corr_pulse, 0);
    chk("R1 dir_up at reset", dir_up, 0);
    chk("R1 unlocked at reset", unlocked, 0);

    // Near-exhaustive sweep of ratio and line period.
    for (int n = 2; n <= 5; n++)
      for (int l = 2 * n + 1; l <= 8 * n; l++)
        run_cfg(n, l);

    // Saturation at both ends (R7).
    run_cfg(40, 320);
    run_cfg(40, 81);

    // Lost closing edge after the estimate window closed (R9).
    do_reset(4);
    line_period(6);
    repeat (33 - 6) @(negedge clk);
    chk("R8 no unlock before limit", unlocked, 0);
    @(negedge clk);
    chk("R8 unlock after limit", unlocked, 1);
    chk("R9 partial error applied", trim, MID - 17);
    repeat (25) @(negedge clk);
    chk("R9 trim held while unlocked", trim, MID - 17);
    chk("R9 pulse ended by unlock", corr_pulse, 0);
    chk("R5 direction fast", dir_up, 0);
    line_sq = 1'b1;
    @(negedge clk);
    chk("R8 relock on edge", unlocked, 0);
    line_sq = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule